// File: doc/BRIEF.md
# Floppy Controller Command Port

This block is the byte-wide host side of a floppy disk controller's command interface. The host pushes a command one byte at a time into a single data port. The block works out the total command length from the opcode in the first byte, so the host never has to program an index. Once the final byte arrives, the block presents the whole command to an execution engine with a one-cycle strobe. When the engine hands back its result bytes, the block plays them out to the host through the same port.

A read-only status byte is always visible on its own output. It reports whether the port can transfer a byte, which way the next byte flows, whether programmed-I/O mode is on, whether a command is in progress, and which drives are positioning their heads. Reading this byte has no side effect. After every byte that moves through the port, readiness drops for a programmable number of clocks. This models the controller's response time.

In programmed-I/O mode an interrupt line is held high whenever the port is waiting on the host to move a byte of a command in progress.

Top module: `fdc_cmd_port`

## Requirements
- R1: Status byte layout: bit 7 ready, bit 6 direction, bit 5 follows `pio_mode`, bit 4 busy, bits 3..0 follow `seek_busy[3..0]`. It is a plain output with no read side effect. After reset it reads ready=1, direction=0 and busy=0.
- R2: Direction reads 0 while command bytes are being collected and while waiting for the engine. It reads 1 while result bytes remain to be read.
- R3: The total command length is decoded from opcode bits 4..0, and bits 7..5 are ignored:
  - 9 bytes for 02, 05, 06, 09 and 0C
  - 6 bytes for 0D
  - 3 bytes for 03 and 0F
  - 2 bytes for 04, 07 and 0A
  - 1 byte for 08
  - every other code is unknown.
- R4: `cmd_valid` is high for exactly the one cycle after the clock edge that accepts the last command byte. In that cycle, `cmd_len` carries the length and `cmd_bytes` byte k (bits 8k+7..8k) holds the k-th byte received, with the opcode at k=0.
- R5: Busy rises at the edge that accepts the first command byte. It stays high until the edge that accepts the last result byte, or the edge where the engine replies with zero result bytes.
- R6: After each accepted write or read, ready is low for exactly `resp_delay` cycles and then returns. It is also low while waiting for the engine.
- R7: An unknown opcode produces no strobe. It yields exactly one result byte of value 80h (interrupt code 10, invalid command).
- R8: `irq` is high exactly when `pio_mode`=1, ready=1 and busy=1.
- R9: A write while direction=1 or ready=0 is ignored. A read while direction=0 or ready=0 is ignored. The current result byte and the collection progress stay unchanged.
- R10: A pulse on `res_valid` while waiting for the engine loads `res_len` bytes from `res_bytes`, byte k at bits 8k+7..8k. They are read out in order k=0,1,... on `host_rdata`, which is 0 outside the result phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the data port |
| host_rd | input | 1 | Host read strobe for the data port |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Current result byte, 0 outside the result phase |
| msr | output | 8 | Status byte |
| irq | output | 1 | Programmed-I/O byte request |
| pio_mode | input | 1 | 1 selects programmed-I/O transfer mode |
| seek_busy | input | 4 | Per-drive head positioning flags |
| resp_delay | input | 4 | Ready gap in clocks after each transfer |
| cmd_valid | output | 1 | Complete command strobe to the engine |
| cmd_len | output | 4 | Length of the presented command |
| cmd_bytes | output | 72 | Collected command bytes |
| res_valid | input | 1 | Engine result strobe |
| res_len | input | 4 | Number of result bytes, 0 to 9 |
| res_bytes | input | 72 | Result bytes from the engine |

## Verification
Every accepted byte changes the status, the interrupt and the strobe one clock edge after it is sampled. Ready then returns `resp_delay` edges after that. A loaded result shows on `host_rdata` one edge after `res_valid`. The bench drives stimulus just after the falling edge, advances its queue-based model on the rising edge, and compares every output at the next falling edge. Each comparison therefore looks at the cycle where that result is due. Directed checks also count the low cycles of ready and read back result bytes at the port after stimulus that should have been ignored.

// File: rtl/fdc_fe_pkg.sv
package fdc_fe_pkg;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_EXEC = 2'd1,
    PH_RES  = 2'd2
  } fe_phase_e;

  localparam logic [7:0] ST0_INVALID = 8'h80;

endpackage

// File: rtl/fdc_len_decode.sv
module fdc_len_decode #(
  parameter int LEN_W = 4
) (
  input  logic [7:0]       opcode,
  output logic [LEN_W-1:0] total_len,
  output logic             known
);

  always_comb begin
    known = 1'b1;
    unique case (opcode[4:0])
      5'h02, 5'h05, 5'h06, 5'h09, 5'h0C: total_len = LEN_W'(9);
      5'h0D:                             total_len = LEN_W'(6);
      5'h03, 5'h0F:                      total_len = LEN_W'(3);
      5'h04, 5'h07, 5'h0A:               total_len = LEN_W'(2);
      5'h08:                             total_len = LEN_W'(1);
      default: begin
        total_len = '0;
        known     = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fdc_resp_timer.sv
module fdc_resp_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             ready
);

  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - DLY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == '0);

  AST_GAP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !ready); // R6
  AST_GAP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == DLY_W'(1)) |=> ready); // R6

endmodule

// File: rtl/fdc_byte_gather.sv
module fdc_byte_gather #(
  parameter int DW    = 8,
  parameter int MAXB  = 9,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               clr,
  input  logic [DW-1:0]      din,
  output logic [CNT_W-1:0]   count,
  output logic [MAXB*DW-1:0] bytes_flat
);

  logic [CNT_W-1:0] count_q, count_d;
  logic [DW-1:0]    slot_q [MAXB];

  always_comb begin
    count_d = count_q;
    if (clr)
      count_d = '0;
    else if (push && count_q < CNT_W'(MAXB))
      count_d = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  for (genvar g = 0; g < MAXB; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (push && count_q == CNT_W'(g))
        slot_q[g] <= din;
    end
    assign bytes_flat[g*DW +: DW] = slot_q[g];
  end

  assign count = count_q;

  AST_GATHER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(MAXB)); // R3

endmodule

// File: rtl/fdc_result_queue.sv
module fdc_result_queue #(
  parameter int DW    = 8,
  parameter int MAXB  = 9,
  parameter int CNT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_len,
  input  logic [MAXB*DW-1:0] load_flat,
  input  logic               pop,
  output logic [DW-1:0]      head,
  output logic [CNT_W-1:0]   remaining
);

  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [CNT_W-1:0] len_clamped;
  logic [DW-1:0]    slot_q [MAXB];

  assign len_clamped = (load_len > CNT_W'(MAXB)) ? CNT_W'(MAXB) : load_len;

  always_comb begin
    idx_d = idx_q;
    rem_d = rem_q;
    if (load) begin
      idx_d = '0;
      rem_d = len_clamped;
    end else if (pop && rem_q != '0) begin
      idx_d = idx_q + CNT_W'(1);
      rem_d = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rem_q <= '0;
    end else begin
      idx_q <= idx_d;
      rem_q <= rem_d;
    end
  end

  for (genvar g = 0; g < MAXB; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (load)
        slot_q[g] <= load_flat[g*DW +: DW];
    end
  end

  always_comb begin
    head = '0;
    for (int k = 0; k < MAXB; k++)
      if (idx_q == CNT_W'(k)) head = slot_q[k];
  end

  assign remaining = rem_q;

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !load) |-> rem_q != '0); // R10

endmodule

// File: rtl/fdc_cmd_port.sv
module fdc_cmd_port
  import fdc_fe_pkg::*;
#(
  parameter  int DW    = 8,
  parameter  int MAXB  = 9,
  parameter  int DLY_W = 4,
  localparam int CNT_W = $clog2(MAXB + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  output logic [7:0]         msr,
  output logic               irq,
  input  logic               pio_mode,
  input  logic [3:0]         seek_busy,
  input  logic [DLY_W-1:0]   resp_delay,
  output logic               cmd_valid,
  output logic [CNT_W-1:0]   cmd_len,
  output logic [MAXB*DW-1:0] cmd_bytes,
  input  logic               res_valid,
  input  logic [CNT_W-1:0]   res_len,
  input  logic [MAXB*DW-1:0] res_bytes
);

  fe_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0] need_q, need_d;
  logic [CNT_W-1:0] clen_q, clen_d;
  logic             strobe_q, strobe_d;

  logic             t_ready;
  logic [CNT_W-1:0] g_cnt;
  logic [CNT_W-1:0] dec_len;
  logic             dec_known;
  logic [DW-1:0]    rq_head;
  logic [CNT_W-1:0] rq_rem;

  logic             mrq, dio, busy;
  logic             wr_acc, rd_acc, first, bad_op, last_byte;
  logic [CNT_W-1:0] eff_len;
  logic             eng_reply, rq_load;
  logic [CNT_W-1:0] rq_len;
  logic [MAXB*DW-1:0] rq_flat;

  // handshake qualifiers
  assign mrq    = t_ready && (phase_q != PH_EXEC);
  assign dio    = (phase_q == PH_RES);
  assign busy   = (phase_q != PH_CMD) || (g_cnt != '0);
  assign wr_acc = host_wr && mrq && !dio;
  assign rd_acc = host_rd && mrq && dio;

  assign first     = (g_cnt == '0);
  assign eff_len   = first ? dec_len : need_q;
  assign bad_op    = wr_acc && first && !dec_known;
  assign last_byte = wr_acc && !bad_op && ((g_cnt + CNT_W'(1)) == eff_len);

  assign eng_reply = (phase_q == PH_EXEC) && res_valid;
  assign rq_load   = bad_op || (eng_reply && res_len != '0);
  assign rq_len    = bad_op ? CNT_W'(1) : res_len;
  assign rq_flat   = bad_op ? {{((MAXB-1)*DW){1'b0}}, DW'(ST0_INVALID)} : res_bytes;

  fdc_len_decode #(.LEN_W(CNT_W)) u_dec (
    .opcode    (host_wdata[7:0]),
    .total_len (dec_len),
    .known     (dec_known)
  );

  fdc_resp_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_acc || rd_acc),
    .load_val (resp_delay),
    .ready    (t_ready)
  );

  fdc_byte_gather #(.DW(DW), .MAXB(MAXB), .CNT_W(CNT_W)) u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (wr_acc && !bad_op),
    .clr        (bad_op || last_byte),
    .din        (host_wdata),
    .count      (g_cnt),
    .bytes_flat (cmd_bytes)
  );

  fdc_result_queue #(.DW(DW), .MAXB(MAXB), .CNT_W(CNT_W)) u_resq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rq_load),
    .load_len  (rq_len),
    .load_flat (rq_flat),
    .pop       (rd_acc),
    .head      (rq_head),
    .remaining (rq_rem)
  );

  // next state
  always_comb begin
    phase_d  = phase_q;
    need_d   = need_q;
    clen_d   = clen_q;
    strobe_d = 1'b0;
    unique case (phase_q)
      PH_CMD: begin
        if (wr_acc && first && dec_known)
          need_d = dec_len;
        if (bad_op) begin
          phase_d = PH_RES;
        end else if (last_byte) begin
          phase_d  = PH_EXEC;
          clen_d   = eff_len;
          strobe_d = 1'b1;
        end
      end
      PH_EXEC: begin
        if (eng_reply)
          phase_d = (res_len == '0) ? PH_CMD : PH_RES;
      end
      PH_RES: begin
        if (rd_acc && rq_rem == CNT_W'(1))
          phase_d = PH_CMD;
      end
      default: phase_d = PH_CMD;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      need_q   <= '0;
      clen_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      need_q   <= need_d;
      clen_q   <= clen_d;
      strobe_q <= strobe_d;
    end
  end

  assign msr        = {mrq, dio, pio_mode, busy, seek_busy};
  assign irq        = pio_mode && mrq && busy;
  assign host_rdata = dio ? rq_head : '0;
  assign cmd_valid  = strobe_q;
  assign cmd_len    = clen_q;

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R4
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (msr[4] && !msr[7])); // R5
  AST_BAD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |=> !cmd_valid); // R7
  AST_BAD_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |=> (msr[6] && rq_rem == CNT_W'(1) && host_rdata == DW'(ST0_INVALID))); // R7
  AST_IRQ_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (t_ready && g_cnt != '0 || phase_q == PH_RES)); // R8
  AST_WRONG_DIR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && phase_q == PH_CMD) |=> $stable(g_cnt)); // R9
  AST_DIO_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    msr[6] |-> msr[4]); // R2

endmodule

// File: tb/fdc_cmd_port_test.sv
module fdc_cmd_port_test;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        host_wr, host_rd;
  logic [7:0]  host_wdata, host_rdata, msr;
  logic        irq, pio_mode;
  logic [3:0]  seek_busy, resp_delay;
  logic        cmd_valid;
  logic [3:0]  cmd_len;
  logic [71:0] cmd_bytes;
  logic        res_valid;
  logic [3:0]  res_len;
  logic [71:0] res_bytes;

  fdc_cmd_port uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .msr(msr), .irq(irq),
    .pio_mode(pio_mode), .seek_busy(seek_busy), .resp_delay(resp_delay),
    .cmd_valid(cmd_valid), .cmd_len(cmd_len), .cmd_bytes(cmd_bytes),
    .res_valid(res_valid), .res_len(res_len), .res_bytes(res_bytes)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int         m_phase;   // 0 collect, 1 engine, 2 result
  logic [7:0] q_cmd[$];
  logic [7:0] q_res[$];
  logic [7:0] exp_cmd[$];
  int         m_len, m_tmr, m_cmdlen;
  bit         m_strobe, m_mrq, m_load;

  function automatic int ref_len(logic [7:0] op);
    case (op[4:0])
      5'h02, 5'h05, 5'h06, 5'h09, 5'h0C: return 9;
      5'h0D: return 6;
      5'h03, 5'h0F: return 3;
      5'h04, 5'h07, 5'h0A: return 2;
      5'h08: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; q_cmd.delete(); q_res.delete(); exp_cmd.delete();
      m_len = 0; m_tmr = 0; m_cmdlen = 0; m_strobe = 0;
    end else begin
      m_mrq    = (m_tmr == 0) && (m_phase != 1);
      m_load   = 0;
      m_strobe = 0;
      case (m_phase)
        0: if (host_wr && m_mrq) begin
             m_load = 1;
             if (q_cmd.size() == 0) m_len = ref_len(host_wdata);
             if (q_cmd.size() == 0 && m_len == 0) begin
               q_res.delete(); q_res.push_back(8'h80); m_phase = 2;
             end else begin
               q_cmd.push_back(host_wdata);
               if (q_cmd.size() == m_len) begin
                 exp_cmd = q_cmd; q_cmd.delete();
                 m_phase = 1; m_strobe = 1; m_cmdlen = m_len;
               end
             end
           end
        1: if (res_valid) begin
             if (res_len == 0) m_phase = 0;
             else begin
               q_res.delete();
               for (int k = 0; k < int'(res_len); k++) q_res.push_back(res_bytes[k*8 +: 8]);
               m_phase = 2;
             end
           end
        default: if (host_rd && m_mrq) begin
             m_load = 1;
             void'(q_res.pop_front());
             if (q_res.size() == 0) m_phase = 0;
           end
      endcase
      if (m_load) m_tmr = int'(resp_delay);
      else if (m_tmr > 0) m_tmr--;
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_mrq, e_busy;
      e_mrq  = (m_tmr == 0) && (m_phase != 1);
      e_busy = (m_phase != 0) || (q_cmd.size() != 0);
      chk("R1/R2/R5/R6", "msr", msr, {e_mrq, m_phase == 2, pio_mode, e_busy, seek_busy});
      chk("R8", "irq", irq, pio_mode && e_mrq && e_busy);
      chk("R4", "cmd_valid", cmd_valid, m_strobe);
      chk("R10", "rdata", host_rdata, (m_phase == 2) ? q_res[0] : 8'h00);
      if (m_strobe) begin
        chk("R3", "cmd_len", cmd_len, m_cmdlen);
        for (int k = 0; k < exp_cmd.size(); k++)
          chk("R4", "cmd_byte", cmd_bytes[k*8 +: 8], exp_cmd[k]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic host_write(input logic [7:0] b);
    while (!(msr[7] && !msr[6])) step();
    host_wdata = b; host_wr = 1'b1;
    step();
    host_wr = 1'b0;
  endtask

  task automatic host_read(output logic [7:0] b);
    while (!(msr[7] && msr[6])) step();
    b = host_rdata; host_rd = 1'b1;
    step();
    host_rd = 1'b0;
  endtask

  task automatic engine(input int exp_len, input int n, input logic [71:0] data);
    while (!cmd_valid) step();
    chk("R3", "decoded length", cmd_len, exp_len);
    repeat (3) step();
    res_valid = 1'b1; res_len = 4'(n); res_bytes = data;
    step();
    res_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int n;
    rst_n = 0; host_wr = 0; host_rd = 0; host_wdata = 0;
    pio_mode = 0; seek_busy = 0; resp_delay = 0;
    res_valid = 0; res_len = 0; res_bytes = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset status", msr, 8'h80);
    #1 rst_n = 1;
    step();

    pio_mode = 1; seek_busy = 4'b1010; resp_delay = 2;
    step();
    chk("R1", "pio and seek bits", msr[5:0], 6'b101010);

    // one-byte command
    host_write(8'h08);
    engine(1, 2, {56'h0, 8'h00, 8'h20});
    host_read(b); chk("R10", "result byte 0", b, 8'h20);
    host_read(b); chk("R10", "result byte 1", b, 8'h00);
    step(); chk("R5", "busy cleared", msr[4], 1'b0);

    // two-byte command, zero-length reply
    host_write(8'h07);
    chk("R5", "busy after first byte", msr[4], 1'b1);
    chk("R8", "irq during command", irq, 1'b0);
    host_write(8'h01);
    engine(2, 0, '0);
    step(); chk("R5", "busy cleared on empty reply", msr[4], 1'b0);

    // three-byte command with a measured gap and a wrong-direction read
    resp_delay = 3;
    host_write(8'hEF);
    n = 0;
    while (!msr[7]) begin n++; step(); end
    chk("R6", "ready gap length", n, 3);
    chk("R8", "irq when waiting for byte", irq, 1'b1);
    host_rd = 1'b1; step(); host_rd = 1'b0;
    chk("R9", "read in collect phase ignored", msr[6], 1'b0);
    chk("R2", "direction while collecting", msr[6], 1'b0);
    host_write(8'h01);
    host_write(8'h28);
    engine(3, 0, '0);

    // nine-byte command, write while not ready, result phase misuse
    resp_delay = 2;
    host_write(8'h46);
    chk("R6", "not ready after accept", msr[7], 1'b0);
    host_wdata = 8'hEE; host_wr = 1'b1; step(); host_wr = 1'b0;
    for (int k = 1; k < 9; k++) host_write(8'(8'h10 + k));
    engine(9, 7, {16'h0, 8'h77, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11});
    while (!msr[7]) step();
    chk("R2", "direction in result phase", msr[6], 1'b1);
    host_wdata = 8'hAA; host_wr = 1'b1; step(); host_wr = 1'b0;
    chk("R9", "write in result phase ignored", host_rdata, 8'h11);
    for (int k = 0; k < 7; k++) begin
      host_read(b);
      chk("R10", "result order", b, 8'(8'h11 * (k + 1)));
    end

    // unknown opcode
    host_write(8'h1F);
    chk("R7", "no strobe on unknown opcode", cmd_valid, 1'b0);
    chk("R7", "result phase entered", msr[6], 1'b1);
    host_read(b); chk("R7", "invalid result code", b, 8'h80);
    step(); chk("R7", "single result byte", msr[6:4], 3'b010);

    // zero delay and DMA mode
    resp_delay = 0; pio_mode = 0;
    host_write(8'h04);
    chk("R6", "ready stays with zero delay", msr[7], 1'b1);
    chk("R8", "no irq in DMA mode", irq, 1'b0);
    host_write(8'h02);
    engine(2, 1, {64'h0, 8'h5A});
    host_read(b); chk("R10", "single result", b, 8'h5A);
    step(); chk("R5", "idle at end", msr[4], 1'b0);

    repeat (4) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule